// File: doc/BRIEF.md
# Word-Wide Memory with Byte Addressing

This block is a synchronous single-port memory of 4 KB organised as 1024 words of 32 bits, addressed from outside with a 12-bit byte address. Every access moves one whole 4-byte word. The block turns the byte address into a word index by discarding its two lowest bits. An address that does not point at the first byte of a word therefore lands on the word that contains it, with no merging across two words and no per-byte masking.

A caller presents an address each cycle, together with a write enable and write data. Writes take effect on the rising clock edge. The registered read port returns the word that was addressed on the previous cycle. A plain `misaligned` output tells the caller, in the same cycle, that the low two address bits are not zero. The flag is informational and never blocks an access.

Data moves as one word per cycle, with no back-pressure. No protocol is involved, so the ports are plain: the memory accepts an access every cycle and always produces read data one cycle later. Control and status pins are likewise plain.

Top module: `word_ram_byteaddr`

## Requirements
- R1: Each access transfers one full 32-bit word, and the array holds 1024 independent words.
- R2: The word index is byte address bits [11:2]. For example, byte addresses 0x000, 0x004, 0x008 and 0x00C select words 0, 1, 2 and 3.
- R3: `rd_data` is registered. After the rising edge at which an address is sampled, it shows the word that address selects, and it stays unchanged while the address stays and no write occurs.
- R4: `misaligned` is combinational and is 1 exactly when byte address bits [1:0] are not 00. The access still proceeds on the containing word.
- R5: While `rst_n` is low at a rising edge, `rd_data` becomes 0. Reset does not clear the stored words.
- R6: When `wr_en` is high at a rising edge, `wr_data` is stored in the selected word. An unaligned write address (for example 0x002, 0x003 or 0x007) stores into the containing aligned word. A later read with any low two bits returns that data.
- R7: When a read and a write hit the same word in the same cycle, `rd_data` returns the contents from before the write. The new data is returned by the next read.
- R8: The highest word, at bytes 0xFFC to 0xFFF, is word 1023. It does not alias word 0 or any other word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset of the read register |
| byte_addr | input | 12 | Byte address of the access |
| wr_en | input | 1 | Write the selected word at the next rising edge |
| wr_data | input | 32 | Word to store |
| rd_data | output | 32 | Registered word read from the previous cycle's address |
| misaligned | output | 1 | High when the low two address bits are nonzero |

## Verification
Aligned addresses on the first four words and on the last word show whether the index is truncated correctly and whether the ends of the array alias each other. Writes to offsets 1, 2 and 3, read back through the other offsets, show whether the low bits are really discarded rather than merged or shifted. Reading and writing one word in the same cycle, back-to-back accesses, and a reset that arrives after data is stored together tell apart read-before-write ordering, the one-cycle latency, and a reset that wrongly clears the array.

// File: rtl/wram_pkg.sv
package wram_pkg;
  localparam int unsigned WR_BYTE_ADDR_W = 12;
  localparam int unsigned WR_WORD_W      = 32;
  localparam int unsigned WR_LANE_W      = 8;

  typedef enum logic [1:0] {
    OFS_ALIGNED = 2'd0,
    OFS_BYTE1   = 2'd1,
    OFS_HALF    = 2'd2,
    OFS_BYTE3   = 2'd3
  } ofs_e;
endpackage

// File: rtl/wram_addr_xlate.sv
module wram_addr_xlate #(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned WORD_W = 32,
  parameter int unsigned LANE_W = 8,
  localparam int unsigned LANES = WORD_W / LANE_W,
  localparam int unsigned OFS_W = (LANES > 1) ? $clog2(LANES) : 1,
  localparam int unsigned IDX_W = ADDR_W - OFS_W
) (
  input  logic [ADDR_W-1:0] byte_addr,
  output logic [IDX_W-1:0]  word_idx,
  output logic              off_grid
);
  logic [OFS_W-1:0] lane_ofs;

  // Truncation: the low lane bits select a byte inside the word and are dropped.
  assign word_idx = byte_addr[ADDR_W-1:OFS_W];
  assign lane_ofs = byte_addr[OFS_W-1:0];

  generate
    if (LANES > 1) begin : g_multi_lane
      assign off_grid = |lane_ofs;
    end else begin : g_single_lane
      assign off_grid = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/wram_word_store.sv
module wram_word_store #(
  parameter int unsigned IDX_W  = 10,
  parameter int unsigned WORD_W = 32,
  localparam int unsigned DEPTH = 1 << IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  idx,
  input  logic              we,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata
);
  logic [WORD_W-1:0] cells [DEPTH];

  // Storage has no reset; writes land on the rising edge.
  always_ff @(posedge clk) begin
    if (we) cells[idx] <= wdata;
  end

  // Read register samples the pre-write contents (read-before-write).
  always_ff @(posedge clk) begin
    if (!rst_n) rdata <= '0;
    else        rdata <= cells[idx];
  end

  // R6: a write followed by a read of the same word returns the written data
  a_r6_write_then_read: assert property (@(posedge clk) disable iff (!rst_n)
    (we ##1 (!we && idx == $past(idx))) |=> rdata == $past(wdata, 2));

  // R3: with the index held and no write, the read register holds its value
  a_r3_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!we ##1 (!we && idx == $past(idx))) |=> $stable(rdata));
endmodule

// File: rtl/word_ram_byteaddr.sv
module word_ram_byteaddr
  import wram_pkg::*;
#(
  parameter int unsigned ADDR_W = WR_BYTE_ADDR_W,
  parameter int unsigned WORD_W = WR_WORD_W,
  parameter int unsigned LANE_W = WR_LANE_W,
  localparam int unsigned LANES = WORD_W / LANE_W,
  localparam int unsigned OFS_W = (LANES > 1) ? $clog2(LANES) : 1,
  localparam int unsigned IDX_W = ADDR_W - OFS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] byte_addr,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  output logic [WORD_W-1:0] rd_data,
  output logic              misaligned
);
  logic [IDX_W-1:0] word_idx;

  wram_addr_xlate #(
    .ADDR_W(ADDR_W),
    .WORD_W(WORD_W),
    .LANE_W(LANE_W)
  ) u_xlate (
    .byte_addr(byte_addr),
    .word_idx (word_idx),
    .off_grid (misaligned)
  );

  wram_word_store #(
    .IDX_W (IDX_W),
    .WORD_W(WORD_W)
  ) u_store (
    .clk  (clk),
    .rst_n(rst_n),
    .idx  (word_idx),
    .we   (wr_en),
    .wdata(wr_data),
    .rdata(rd_data)
  );

  // R2: the index seen by the array is the byte address with the lane bits dropped
  a_r2_index_truncates: assert property (@(posedge clk) disable iff (!rst_n)
    word_idx == byte_addr[ADDR_W-1:OFS_W]);

  // R4: the flag is high only when the rebuilt aligned address differs from the input
  a_r4_flag_matches_grid: assert property (@(posedge clk) disable iff (!rst_n)
    misaligned == ({word_idx, {OFS_W{1'b0}}} != byte_addr));

  // R5: the first cycle out of reset shows a cleared read register
  a_r5_reset_clears_read: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> rd_data == '0);
endmodule

// File: tb/word_ram_byteaddr_tb.sv
`timescale 1ns/1ps
module word_ram_byteaddr_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] byte_addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        misaligned;

  int n_checks = 0;
  int n_fail = 0;

  typedef struct {
    bit          known;
    logic [31:0] val;
    string       tag;
  } exp_t;

  exp_t        sb_q[$];
  logic [31:0] model [1024];
  bit          written [1024];

  always #2.5 clk = ~clk;

  word_ram_byteaddr u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .byte_addr (byte_addr),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .rd_data   (rd_data),
    .misaligned(misaligned)
  );

  task automatic check32(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  // Driver: one access per cycle, expected read value pushed to the scoreboard
  task automatic access(input logic [11:0] a, input logic we, input logic [31:0] d,
                        input string tag);
    exp_t it;
    int   idx;
    @(negedge clk);
    byte_addr = a;
    wr_en     = we;
    wr_data   = d;
    idx       = int'(a[11:2]);
    it.known  = written[idx];
    it.val    = model[idx];
    it.tag    = tag;
    sb_q.push_back(it);
    if (we) begin
      model[idx]   = d;
      written[idx] = 1'b1;
    end
    #1;
    check32({tag, " R4 flag"}, {31'd0, misaligned}, {31'd0, (a[1:0] != 2'b00)});
  endtask

  task automatic idle_cycle();
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Monitor: the result of the access driven at the last falling edge
  always @(posedge clk) begin
    #1;
    if (sb_q.size() > 0) begin
      exp_t it;
      it = sb_q.pop_front();
      if (it.known) check32(it.tag, rd_data, it.val);
    end
  end

  initial begin
    for (int i = 0; i < 1024; i++) begin
      written[i] = 1'b0;
      model[i]   = '0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    check32("R5 read reg cleared in reset", rd_data, 32'h0);
    rst_n = 1'b1;

    // R2 and R1: the first four aligned words
    access(12'h000, 1'b1, 32'hA0A0_0000, "R2 wr w0");
    access(12'h004, 1'b1, 32'hA1A1_1111, "R2 wr w1");
    access(12'h008, 1'b1, 32'hA2A2_2222, "R2 wr w2");
    access(12'h00C, 1'b1, 32'hA3A3_3333, "R2 wr w3");
    access(12'h000, 1'b0, 32'h0, "R2 rd w0");
    access(12'h004, 1'b0, 32'h0, "R2 rd w1");
    access(12'h008, 1'b0, 32'h0, "R2 rd w2");
    access(12'h00C, 1'b0, 32'h0, "R1 R2 rd w3");

    // R3: the address is held, so the read register keeps its value
    access(12'h00C, 1'b0, 32'h0, "R3 hold w3");
    access(12'h00C, 1'b0, 32'h0, "R3 hold w3 again");

    // R6 and R4: unaligned writes land in the containing word
    access(12'h102, 1'b1, 32'hDEAD_0102, "R6 wr 0x102");
    access(12'h100, 1'b0, 32'h0, "R6 rd 0x100");
    access(12'h103, 1'b0, 32'h0, "R6 rd 0x103");
    access(12'h007, 1'b1, 32'h7777_0007, "R6 wr 0x007");
    access(12'h004, 1'b0, 32'h0, "R6 rd 0x004 after 0x007");
    access(12'h005, 1'b0, 32'h0, "R4 rd 0x005");
    access(12'h000, 1'b0, 32'h0, "R6 w0 untouched");

    // R7: read and write of one word in the same cycle
    access(12'h200, 1'b1, 32'h1111_2222, "R7 first wr");
    access(12'h201, 1'b1, 32'h3333_4444, "R7 old data on collision");
    access(12'h202, 1'b0, 32'h0, "R7 new data next read");

    // R8: top word vs bottom word
    access(12'hFFC, 1'b1, 32'hFFFF_0FFC, "R8 wr top");
    access(12'h000, 1'b0, 32'h0, "R8 w0 not aliased");
    access(12'hFFF, 1'b0, 32'h0, "R8 rd top via 0xFFF");
    access(12'hFFD, 1'b1, 32'h5A5A_A5A5, "R8 wr top via 0xFFD");
    access(12'hFFE, 1'b0, 32'h0, "R8 rd top via 0xFFE");
    access(12'h3FC, 1'b0, 32'h0, "R8 neighbour probe");

    // R5: reset clears the read register, not the array
    idle_cycle();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check32("R5 read reg cleared by reset", rd_data, 32'h0);
    rst_n = 1'b1;
    access(12'h104, 1'b0, 32'h0, "R5 w0x104 unknown, spacer");
    access(12'h100, 1'b0, 32'h0, "R5 array kept after reset");
    access(12'h008, 1'b0, 32'h0, "R5 w2 kept after reset");
    idle_cycle();
    idle_cycle();
    idle_cycle();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #100000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule